// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs one complete block erase on a command-driven flash array built from one or more identical chips that sit side by side on a common data bus. A single start pulse with a block address is enough. The block first checks that the array is ready, then raises the programming voltage enable. It clears the status register and sends the two-step erase command. It waits a settle interval and polls for completion. Last, it rereads and decodes the status and returns a single result code.

All commands are sent to the block address and copied into every chip lane of the bus word. Status is read per chip from the low byte of that chip's lane. The array counts as ready only when every chip shows its ready bit (bit 7). The error bytes of all chips are ORed into one byte before decoding. A plain erase failure restarts the operation from the readiness check a limited number of times.

Top module: `ers_block_erase`

## Requirements
- R1: After reset, `busy`, `done`, `bus_req` and `vpp_en` are all low.
- R2: On a start while idle, the first bus write is 0x70. Status is then read until bit 7 is set in every chip lane. Next come the writes 0x50, 0x20 and 0xD0, with `vpp_en` high for all three. Every command goes to the start address, copied into each lane (command value in bits 7:0 of the lane, upper lane bits zero).
- R3: After the 0xD0 write is accepted, no status read is issued for at least `SETTLE_CYC` cycles.
- R4: After the settle interval, status is polled and no bus write is issued until bit 7 is set in every lane.
- R5: If the completion poll runs past `POLL_TMO` cycles, the block writes 0x70 while `vpp_en` is still high, then drops `vpp_en` and reports timeout (code 5).
- R6: On completion, `vpp_en` drops before a 0x70 write and a status reread. If the merged status has no bit set in mask 0x3A, the result is ok (code 0) and no further write is issued.
- R7: If the merged status has any bit in mask 0x3A set, the block writes 0x50 and then 0x70, both with `vpp_en` low, before it reports or retries.
- R8: The decode order is: bits 5 and 4 both set gives command-sequence error (code 2). Otherwise bit 1 gives protected (code 1). Otherwise bit 3 gives low voltage (code 3). Otherwise bit 5 gives erase failed (code 4). Otherwise the result is ok (code 0).
- R9: An erase failure restarts from the readiness reread with no 0x70 write and no new start. At most `MAX_RETRY` (3) restarts happen. A failure on the last permitted attempt reports erase failed (code 4).
- R10: Status bytes of all chip lanes are ORed before decoding. For example, bit 4 in one chip and bit 5 in another gives a command-sequence error.
- R11: If the readiness check does not see bit 7 in every lane within `RDY_TMO` cycles, the block reports timeout (code 5). It issues nothing after the first 0x70 write, and `vpp_en` never rises.
- R12: `done` is a one-cycle pulse that carries `result`. `busy` is high from the cycle after an accepted start until the cycle of `done`. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an erase (accepted only when idle) |
| start_addr | input | ADDR_W | Block address for all commands and reads |
| busy | output | 1 | An erase is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | 0 ok, 1 protected, 2 command-sequence, 3 low voltage, 4 erase failed, 5 timeout |
| bus_req | output | 1 | Bus transfer request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | ADDR_W | Transfer address |
| bus_wdata | output | CHIPS*CHIP_W | Write data (command in every lane) |
| bus_rdata | input | CHIPS*CHIP_W | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer completion strobe |
| vpp_en | output | 1 | Programming voltage enable |

## Verification
The hardest paths to reach are the retry limit and the cross-chip merge. The retry limit takes an array that reports a plain failure on a chosen number of consecutive attempts and then either recovers or keeps failing. So the flash model in the bench counts the confirm commands and serves a failure byte until the configured count is reached. The merge case needs each chip to hold a byte that means nothing alone but decodes differently when ORed. The two lanes also finish at different times, so the poll must wait for the slower chip. The model therefore gives every lane its own busy countdown and its own error byte. Any write that arrives while a lane is still busy is flagged.

// File: rtl/ers_pkg.sv
package ers_pkg;

  typedef enum logic [2:0] {
    RES_OK     = 3'd0,
    RES_PROT   = 3'd1,
    RES_CMDSEQ = 3'd2,
    RES_LOWV   = 3'd3,
    RES_EFAIL  = 3'd4,
    RES_TMO    = 3'd5
  } ers_result_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RDY_CMD, S_RDY_RD, S_CLR, S_SETUP, S_CONF, S_SETTLE,
    S_POLL, S_TO_CMD, S_RECMD, S_RERD, S_ERR_CLR, S_ERR_RS
  } ers_state_e;

  localparam logic [7:0] CMD_RDSTAT  = 8'h70;
  localparam logic [7:0] CMD_CLRSTAT = 8'h50;
  localparam logic [7:0] CMD_ESETUP  = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] ERR_MASK    = 8'h3A;

  function automatic ers_result_e decode_status(input logic [7:0] s);
    if (s[5] && s[4])  return RES_CMDSEQ;
    else if (s[1])     return RES_PROT;
    else if (s[3])     return RES_LOWV;
    else if (s[5])     return RES_EFAIL;
    else               return RES_OK;
  endfunction

endpackage

// File: rtl/ers_bus_port.sv
module ers_bus_port #(
  parameter int ADDR_W = 24,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_we,
  input  logic [ADDR_W-1:0] go_addr,
  input  logic [DW-1:0]     go_data,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ack,
  output logic              xfer_done,
  output logic [DW-1:0]     rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      xfer_done <= 1'b0;
      rd_data   <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (bus_req) begin
        if (bus_ack) begin
          bus_req   <= 1'b0;
          xfer_done <= 1'b1;
          if (!bus_we) rd_data <= bus_rdata;
        end
      end else if (go) begin
        bus_req   <= 1'b1;
        bus_we    <= go_we;
        bus_addr  <= go_addr;
        bus_wdata <= go_data;
      end
    end
  end

  // R2
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)));

endmodule

// File: rtl/ers_status_merge.sv
module ers_status_merge #(
  parameter int CHIPS  = 2,
  parameter int CHIP_W = 8
) (
  input  logic [CHIPS*CHIP_W-1:0] word,
  output logic                    all_ready,
  output logic [7:0]              merged
);

  logic [7:0] lane [CHIPS];

  for (genvar g = 0; g < CHIPS; g++) begin : g_lane
    assign lane[g] = word[g*CHIP_W +: 8];
  end

  always_comb begin
    all_ready = 1'b1;
    merged    = 8'h00;
    for (int i = 0; i < CHIPS; i++) begin
      all_ready = all_ready & lane[i][7];
      merged    = merged | lane[i];
    end
  end

endmodule

// File: rtl/ers_timer.sv
module ers_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= limit;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/ers_block_erase.sv
module ers_block_erase
  import ers_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CHIPS      = 2,
  parameter int CHIP_W     = 8,
  parameter int RDY_TMO    = 50000000,
  parameter int SETTLE_CYC = 50000000,
  parameter int POLL_TMO   = 1000000000,
  parameter int MAX_RETRY  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       start_addr,
  output logic                    busy,
  output logic                    done,
  output logic [2:0]              result,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [CHIPS*CHIP_W-1:0] bus_wdata,
  input  logic [CHIPS*CHIP_W-1:0] bus_rdata,
  input  logic                    bus_ack,
  output logic                    vpp_en
);

  localparam int DW    = CHIPS * CHIP_W;
  localparam int T_A   = (RDY_TMO > SETTLE_CYC) ? RDY_TMO : SETTLE_CYC;
  localparam int T_MAX = (T_A > POLL_TMO) ? T_A : POLL_TMO;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int RW    = $clog2(MAX_RETRY + 2);

  function automatic logic [DW-1:0] rep_cmd(input logic [7:0] c);
    logic [DW-1:0] r;
    r = '0;
    for (int i = 0; i < CHIPS; i++) r[i*CHIP_W +: 8] = c;
    return r;
  endfunction

  ers_state_e   state;
  logic [ADDR_W-1:0] addr_q;
  logic         issued;
  logic [RW-1:0] retry_q;
  logic         vpp_q;
  logic         done_q;
  ers_result_e  res_q;
  logic [7:0]   stat_q;

  logic         bus_st, cmd_we, go;
  logic [7:0]   cmd_byte;
  logic         xfer_done;
  logic [DW-1:0] rd_word;
  logic         mrg_ready;
  logic [7:0]   mrg_byte;
  logic         tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;
  ers_result_e  dec;
  logic         do_retry;

  // command selection per state
  always_comb begin
    bus_st   = 1'b1;
    cmd_we   = 1'b1;
    cmd_byte = 8'h00;
    case (state)
      S_RDY_CMD: cmd_byte = CMD_RDSTAT;
      S_RDY_RD:  cmd_we   = 1'b0;
      S_CLR:     cmd_byte = CMD_CLRSTAT;
      S_SETUP:   cmd_byte = CMD_ESETUP;
      S_CONF:    cmd_byte = CMD_CONFIRM;
      S_POLL:    cmd_we   = 1'b0;
      S_TO_CMD:  cmd_byte = CMD_RDSTAT;
      S_RECMD:   cmd_byte = CMD_RDSTAT;
      S_RERD:    cmd_we   = 1'b0;
      S_ERR_CLR: cmd_byte = CMD_CLRSTAT;
      S_ERR_RS:  cmd_byte = CMD_RDSTAT;
      default:   bus_st   = 1'b0;
    endcase
  end

  assign go = bus_st && !issued && !bus_req;

  ers_bus_port #(.ADDR_W(ADDR_W), .DW(DW)) u_port (
    .clk(clk), .rst(rst), .go(go), .go_we(cmd_we), .go_addr(addr_q),
    .go_data(rep_cmd(cmd_byte)), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .xfer_done(xfer_done), .rd_data(rd_word)
  );

  ers_status_merge #(.CHIPS(CHIPS), .CHIP_W(CHIP_W)) u_merge (
    .word(rd_word), .all_ready(mrg_ready), .merged(mrg_byte)
  );

  assign dec      = decode_status(stat_q);
  assign do_retry = (dec == RES_EFAIL) && (retry_q < RW'(MAX_RETRY));

  // timer reload points
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = TW'(RDY_TMO);
    case (state)
      S_RDY_CMD: tmr_load = xfer_done;
      S_ERR_RS:  tmr_load = xfer_done && do_retry;
      S_CONF:    begin tmr_load = xfer_done; tmr_val = TW'(SETTLE_CYC); end
      S_SETTLE:  begin tmr_load = tmr_exp;   tmr_val = TW'(POLL_TMO);   end
      default:   tmr_load = 1'b0;
    endcase
  end

  ers_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .limit(tmr_val), .expired(tmr_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      issued  <= 1'b0;
      retry_q <= '0;
      vpp_q   <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= RES_OK;
      stat_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (go)             issued <= 1'b1;
      else if (xfer_done) issued <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          addr_q  <= start_addr;
          retry_q <= '0;
          state   <= S_RDY_CMD;
        end
        S_RDY_CMD: if (xfer_done) state <= S_RDY_RD;
        S_RDY_RD: if (xfer_done) begin
          if (mrg_ready) begin
            vpp_q <= 1'b1;
            state <= S_CLR;
          end else if (tmr_exp) begin
            res_q  <= RES_TMO;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_CLR:    if (xfer_done) state <= S_SETUP;
        S_SETUP:  if (xfer_done) state <= S_CONF;
        S_CONF:   if (xfer_done) state <= S_SETTLE;
        S_SETTLE: if (tmr_exp)   state <= S_POLL;
        S_POLL: if (xfer_done) begin
          if (mrg_ready) begin
            vpp_q <= 1'b0;
            state <= S_RECMD;
          end else if (tmr_exp) begin
            state <= S_TO_CMD;
          end
        end
        S_TO_CMD: if (xfer_done) begin
          vpp_q  <= 1'b0;
          res_q  <= RES_TMO;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_RECMD: if (xfer_done) state <= S_RERD;
        S_RERD: if (xfer_done) begin
          stat_q <= mrg_byte;
          if ((mrg_byte & ERR_MASK) != 8'h00) begin
            state <= S_ERR_CLR;
          end else begin
            res_q  <= RES_OK;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        S_ERR_CLR: if (xfer_done) state <= S_ERR_RS;
        S_ERR_RS: if (xfer_done) begin
          if (do_retry) begin
            retry_q <= retry_q + 1'b1;
            state   <= S_RDY_RD;
          end else begin
            res_q  <= dec;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = done_q;
  assign result = res_q;
  assign vpp_en = vpp_q;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R2
  vpp_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(vpp_en) |-> (state == S_CLR));

  // R9
  retry_bound_chk: assert property (@(posedge clk) disable iff (rst) retry_q <= RW'(MAX_RETRY));

  // R8
  cmdseq_src_chk: assert property (@(posedge clk) disable iff (rst)
    (done && result == RES_CMDSEQ) |-> (stat_q[5] && stat_q[4]));

  // R11
  idle_vpp_chk: assert property (@(posedge clk) disable iff (rst) (state == S_IDLE) |-> !vpp_en);

endmodule

// File: tb/tb_ers_block_erase.sv
module tb_ers_block_erase;
  localparam int CLK_P  = 10;
  localparam int AW     = 24;
  localparam int NCH    = 2;
  localparam int CW     = 8;
  localparam int DW     = NCH * CW;
  localparam int RDY_T  = 30;
  localparam int SET_T  = 12;
  localparam int POL_T  = 60;
  localparam int RETRY  = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic busy, done, bus_req, bus_we, bus_ack, vpp_en;
  logic [2:0] result;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  always #(CLK_P/2) clk = ~clk;

  ers_block_erase #(.ADDR_W(AW), .CHIPS(NCH), .CHIP_W(CW), .RDY_TMO(RDY_T),
    .SETTLE_CYC(SET_T), .POLL_TMO(POL_T), .MAX_RETRY(RETRY)) dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .busy(busy),
    .done(done), .result(result), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .vpp_en(vpp_en));

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- flash array model ----------------
  int cyc = 0, d0_cyc = 0, gap = 0, viol = 0, attempt = 0, dones = 0;
  int busy_l [NCH];
  logic [6:0] err_l [NCH], pend_l [NCH];
  bit waiting_rd = 0, hold = 0;
  int m_fn = 0, m_bsy = 1, m_skew = 0;
  logic [7:0] m_f [NCH], m_z [NCH];
  logic [AW-1:0] cur_addr = '0;
  int log_q [$];
  logic [DW-1:0] rd_nx;

  initial begin
    bus_ack = 1'b0; bus_rdata = '0;
    for (int l = 0; l < NCH; l++) begin busy_l[l] = 0; err_l[l] = '0; pend_l[l] = '0; end
  end

  always @(posedge clk) begin
    cyc++;
    if (rst) bus_ack <= 1'b0;
    else begin
      bus_ack <= bus_req && !bus_ack;
      for (int l = 0; l < NCH; l++)
        if (busy_l[l] > 0) begin
          busy_l[l]--;
          if (busy_l[l] == 0) err_l[l] = pend_l[l];
        end
      if (bus_req && !bus_ack) begin
        if (bus_addr !== cur_addr) viol++;
        if (bus_we) begin
          for (int l = 0; l < NCH; l++)
            if (bus_wdata[l*CW +: CW] !== {{(CW-8){1'b0}}, bus_wdata[7:0]}) viol++;
          for (int l = 0; l < NCH; l++) if (busy_l[l] > 0) viol++;
          log_q.push_back({23'd0, vpp_en, bus_wdata[7:0]});
          if (bus_wdata[7:0] == 8'h50) for (int l = 0; l < NCH; l++) err_l[l] = '0;
          if (bus_wdata[7:0] == 8'hD0) begin
            attempt++;
            d0_cyc = cyc; waiting_rd = 1;
            for (int l = 0; l < NCH; l++) begin
              busy_l[l] = m_bsy + l * m_skew;
              pend_l[l] = (attempt <= m_fn) ? m_f[l][6:0] : m_z[l][6:0];
            end
          end
        end else begin
          if (waiting_rd) begin
            if (gap == 0 || cyc - d0_cyc < gap) gap = cyc - d0_cyc;
            waiting_rd = 0;
          end
          for (int l = 0; l < NCH; l++)
            rd_nx[l*CW +: CW] = {{(CW-8){1'b0}}, (!hold && busy_l[l] == 0), err_l[l]};
          bus_rdata <= rd_nx;
        end
      end
    end
  end

  // ---------------- per-clock reference for busy/done ----------------
  bit ref_busy = 0;
  int exp_code = 0;
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      if (done) begin
        dones++;
        chk(busy == 1'b0 && ref_busy, "R12", "busy at done", busy, 0);
        chk(result == exp_code[2:0], "R8", "result code", result, exp_code);
        ref_busy = 0;
      end else if (busy !== ref_busy) begin
        chk(0, "R12", "busy per clock", busy, ref_busy);
      end
    end
  end

  // ---------------- behavioural expectation ----------------
  int exp_q [$];
  task automatic predict(input bit tmo);
    int a;
    logic [7:0] st;
    exp_q.delete();
    exp_q.push_back(32'h070);
    if (hold) begin exp_code = 5; return; end
    a = 0;
    forever begin
      exp_q.push_back(32'h150); exp_q.push_back(32'h120); exp_q.push_back(32'h1D0);
      if (tmo) begin exp_q.push_back(32'h170); exp_code = 5; return; end
      exp_q.push_back(32'h070);
      st = 8'h00;
      for (int l = 0; l < NCH; l++) st |= (a < m_fn) ? m_f[l] : m_z[l];
      st &= 8'h7F;
      if ((st & 8'h3A) == 0) begin exp_code = 0; return; end
      exp_q.push_back(32'h050); exp_q.push_back(32'h070);
      if (st[5] && st[4])  begin exp_code = 2; return; end
      else if (st[1])      begin exp_code = 1; return; end
      else if (st[3])      begin exp_code = 3; return; end
      else if (st[5]) begin
        if (a < RETRY) a++;
        else begin exp_code = 4; return; end
      end else begin exp_code = 0; return; end
    end
  endtask

  task automatic run_case(input string req, input int fn, input logic [7:0] f0, f1, z0, z1,
                          input int bsy, input int skew, input bit hd, input bit tmo, input bit again);
    int d_before;
    bit same;
    @(negedge clk);
    m_fn = fn; m_f[0] = f0; m_f[1] = f1; m_z[0] = z0; m_z[1] = z1;
    m_bsy = bsy; m_skew = skew; hold = hd;
    for (int l = 0; l < NCH; l++) begin busy_l[l] = 0; err_l[l] = '0; end
    attempt = 0; viol = 0; gap = 0; waiting_rd = 0;
    log_q.delete();
    cur_addr = 24'h040000 + 24'(cyc);
    predict(tmo);
    d_before = dones;
    start_addr = cur_addr; start = 1'b1;
    @(posedge clk); #1 ref_busy = 1;
    @(negedge clk); start = 1'b0;
    if (again) begin
      repeat (4) @(negedge clk);
      start = 1'b1; start_addr = 24'h0;
      @(negedge clk); start = 1'b0;
    end
    while (dones == d_before) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(dones == d_before + 1, req, "single done", dones - d_before, 1);
    same = (log_q.size() == exp_q.size());
    if (same) foreach (exp_q[i]) if (log_q[i] != exp_q[i]) same = 0;
    chk(same, req, "command/vpp sequence length", log_q.size(), exp_q.size());
    chk(vpp_en == 1'b0 && !busy, req, "idle after run", {busy, vpp_en}, 0);
    if (!tmo) chk(viol == 0, req, "protocol violations (R4)", viol, 0);
    if (!hd) chk(gap >= SET_T, "R3", "settle gap", gap, SET_T);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !bus_req && !vpp_en, "R1", "reset outputs",
        {busy, done, bus_req, vpp_en}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!busy && !bus_req && !vpp_en, "R1", "idle after reset", {busy, bus_req, vpp_en}, 0);
    // R2 R4 R6: clean erase, lanes finish at different times
    run_case("R6", 0, 8'h00, 8'h00, 8'h00, 8'h00, 20, 8, 0, 0, 0);
    // R6: bit 2 is outside the mask -> ok, no reset writes
    run_case("R6", 0, 8'h00, 8'h00, 8'h04, 8'h00, 5, 0, 0, 0, 0);
    // R7: bit 4 alone -> reset writes, ok
    run_case("R7", 0, 8'h00, 8'h00, 8'h10, 8'h00, 5, 0, 0, 0, 0);
    // R10: merged bits 4 and 5 -> command-sequence error
    run_case("R10", 0, 8'h00, 8'h00, 8'h10, 8'h20, 5, 3, 0, 0, 0);
    // R8: 0x32 -> command-sequence beats protect
    run_case("R8", 0, 8'h00, 8'h00, 8'h32, 8'h00, 5, 0, 0, 0, 0);
    // R8: protect beats low voltage (merged 0x0A)
    run_case("R8", 0, 8'h00, 8'h00, 8'h02, 8'h08, 5, 0, 0, 0, 0);
    // R8: low voltage beats erase failure
    run_case("R8", 0, 8'h00, 8'h00, 8'h28, 8'h00, 5, 0, 0, 0, 0);
    // R9: two failures then success
    run_case("R9", 2, 8'h20, 8'h00, 8'h00, 8'h00, 5, 0, 0, 0, 0);
    // R9: three failures then success (limit)
    run_case("R9", 3, 8'h00, 8'h20, 8'h00, 8'h00, 5, 0, 0, 0, 0);
    // R9: persistent failure
    run_case("R9", 9, 8'h00, 8'h20, 8'h00, 8'h20, 5, 0, 0, 0, 0);
    // R5: completion never arrives
    run_case("R5", 0, 8'h00, 8'h00, 8'h00, 8'h00, 1000, 0, 0, 1, 0);
    // R11: readiness never seen
    run_case("R11", 0, 8'h00, 8'h00, 8'h00, 8'h00, 5, 0, 1, 0, 0);
    // R12: second start during the run is ignored
    run_case("R12", 0, 8'h00, 8'h00, 8'h00, 8'h00, 5, 0, 0, 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule